// File: doc/BRIEF.md
# Run-Control Unit for Single-Step and PC Breakpoint

This block sits beside a CPU core and decides, every cycle, whether the core may advance. The core is free-running by default. Software can park it by setting a halt request. It can then grant exactly one instruction by writing halt and step together. The step grant lasts until the core reports one retirement, and after that the core is parked again.

A hardware breakpoint compares the core's current PC against a programmed address. On the first match, the core is stopped before that instruction executes. The enable bit drops so that the breakpoint does not trigger again. Both the breakpoint address and its enable can be written while the core is still held in its own reset, so a match on the very first instruction after release is caught.

The controller does not service any wait state of the core. If a granted step lands on an instruction that is blocked waiting on an external handshake, the grant stays open and the core is left waiting.

Top module: `run_ctl_unit`

## Requirements
- R1: After `rst_n` is asserted, the control readback `ctl_rdata` is 0 and `halted` is 0. With the core out of reset, `run_en` is then 1, so the core runs freely.
- R2: While `core_rst` is 1, `run_en` is 0. Writes to the control and breakpoint registers still take effect during this time.
- R3: Writing the control register with bit 0 (halt) set makes `run_en` 0 and `halted` 1 from the next cycle.
- R4: Writing 0x3 (halt plus step, bit 1) while parked makes `run_en` 1 from the next cycle. `run_en` stays 1 up to and including the cycle in which `retire` is 1. On the cycle after that retire, `run_en` is 0 and `halted` is 1.
- R5: The step bit (readback bit 1) reads 1 while the grant is open. It clears by itself on the cycle after the granted retire.
- R6: A write with step set but halt clear does not set the step bit, and the core runs freely.
- R7: When bit 2 (breakpoint enable) is set, the core is not halted and not stepping, and `pc` equals the breakpoint address, `run_en` is 0 in that same cycle. From the next cycle, `halted` is 1 and the halt bit reads 1.
- R8: A breakpoint hit clears the enable bit (readback bit 2). After halt is cleared again, the same address does not stop the core a second time.
- R9: A breakpoint armed while `core_rst` is 1 stops the core on the first cycle after release in which `pc` matches the address.
- R10: While a step grant is open and `retire` stays 0, for example because the core waits on a handshake, `run_en` stays 1 and `halted` stays 0.
- R11: Writing 0 to the control register while parked resumes free running.
- R12: While a step grant is open, a breakpoint match neither stalls the core nor consumes the enable. The enable bit stays set after the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller |
| core_rst | input | 1 | High while the core is held in its own reset |
| ctl_wr | input | 1 | Write strobe for the run-control register |
| ctl_wdata | input | 3 | Run-control value: bit 0 halt, bit 1 step, bit 2 breakpoint enable |
| bp_wr | input | 1 | Write strobe for the breakpoint address |
| bp_wdata | input | PC_W | Breakpoint address to store |
| pc | input | PC_W | Current PC of the core |
| retire | input | 1 | One instruction retired this cycle |
| run_en | output | 1 | Core may advance this cycle |
| halted | output | 1 | Core is parked |
| ctl_rdata | output | 3 | Readback of the run-control register |

## Verification
The bench leaves a step grant open for several cycles with no retire. A design that timed out the grant, or forced a re-halt, would drop `run_en` there. It checks the cycle right after the granted retire, where a late clear lets a second instruction through. It re-visits the breakpoint address after resuming, to catch a design that does not disarm on a hit and so halts the core forever. It also steps across an armed address, to catch a design that stalls the step or spends the breakpoint on it. Finally, it arms the breakpoint under core reset with the matching PC present at release, which exposes a compare that is enabled late or gated by reset for too long.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int CTL_W    = 3;
  localparam int HALT_BIT = 0;
  localparam int STEP_BIT = 1;
  localparam int BPEN_BIT = 2;

  typedef struct packed {
    logic bp_en;
    logic step;
    logic halt;
  } rc_ctl_t;

  // Step is only honoured together with halt.
  function automatic rc_ctl_t decode_wr(input logic [CTL_W-1:0] wd);
    rc_ctl_t c;
    c.halt  = wd[HALT_BIT];
    c.step  = wd[HALT_BIT] & wd[STEP_BIT];
    c.bp_en = wd[BPEN_BIT];
    return c;
  endfunction

  // The core may advance if a step grant is open, or if it is neither
  // parked nor stopped by a breakpoint match. Core reset overrides both.
  function automatic logic may_run(input rc_ctl_t c, input logic hit,
                                   input logic core_rst);
    return !core_rst && (c.step || (!c.halt && !hit));
  endfunction
endpackage

// File: rtl/rc_bp_unit.sv
module rc_bp_unit #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bp_wr,
  input  logic [PC_W-1:0] bp_wdata,
  input  logic [PC_W-1:0] pc,
  input  logic            armed,
  input  logic            gate,
  output logic            bp_hit
);
  logic [PC_W-1:0] bp_addr_q;

  function automatic logic pc_match(input logic [PC_W-1:0] a,
                                    input logic [PC_W-1:0] b);
    return a == b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bp_addr_q <= '0;
    else if (bp_wr) bp_addr_q <= bp_wdata;
  end

  assign bp_hit = armed && gate && pc_match(pc, bp_addr_q);
endmodule

// File: rtl/rc_step_ctrl.sv
module rc_step_ctrl
  import rc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             retire,
  input  logic             bp_hit,
  output rc_ctl_t          ctl_q,
  output logic             run_en,
  output logic             halted
);
  // Named internal events for the assertions.
  logic step_done;
  logic bp_fire;

  assign step_done = ctl_q.step && retire;
  assign bp_fire   = bp_hit && !ctl_q.halt && !ctl_q.step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= decode_wr(ctl_wdata);
    end else begin
      if (step_done) ctl_q.step <= 1'b0;
      if (bp_fire) begin
        ctl_q.halt  <= 1'b1;
        ctl_q.bp_en <= 1'b0;
      end
    end
  end

  assign run_en = may_run(ctl_q, bp_hit, core_rst);
  assign halted = ctl_q.halt && !ctl_q.step;

  // R4: one retire per grant; parked on the following cycle
  a_r4_stall_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !ctl_wr) |=> (!run_en && halted));

  // R5: grant bit drops after it is consumed
  a_r5_step_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !ctl_wr) |=> !ctl_q.step);

  // R7: a match stops the core in the same cycle
  a_r7_bp_stops: assert property (@(posedge clk) disable iff (!rst_n)
    bp_fire |-> !run_en);

  // R8: a hit parks the core and disarms the breakpoint
  a_r8_bp_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_fire && !ctl_wr) |=> (halted && !ctl_q.bp_en));

  // R10: an open grant without retire is left alone
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.step && !retire && !ctl_wr) |=> !halted);

  // R12: stepping across an armed address keeps the enable
  a_r12_step_keeps_bp: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.step && ctl_q.bp_en && bp_hit && !ctl_wr) |=> ctl_q.bp_en);
endmodule

// File: rtl/run_ctl_unit.sv
module run_ctl_unit
  import rc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             bp_wr,
  input  logic [PC_W-1:0]  bp_wdata,
  input  logic [PC_W-1:0]  pc,
  input  logic             retire,
  output logic             run_en,
  output logic             halted,
  output logic [CTL_W-1:0] ctl_rdata
);
  rc_ctl_t ctl_q;
  logic    bp_hit;

  rc_bp_unit #(.PC_W(PC_W)) bp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bp_wr    (bp_wr),
    .bp_wdata (bp_wdata),
    .pc       (pc),
    .armed    (ctl_q.bp_en),
    .gate     (!core_rst),
    .bp_hit   (bp_hit)
  );

  rc_step_ctrl step_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_rst  (core_rst),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .retire    (retire),
    .bp_hit    (bp_hit),
    .ctl_q     (ctl_q),
    .run_en    (run_en),
    .halted    (halted)
  );

  assign ctl_rdata = ctl_q;

  // R2: nothing advances while the core is in reset
  a_r2_core_reset_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !run_en);

  // R3: a halt write parks the core on the next cycle
  a_r3_halt_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata == 3'b001) |=> (halted && !run_en));
endmodule

// File: tb/run_ctl_unit_tb_top.sv
module run_ctl_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int NROWS = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_rst = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [2:0]    ctl_wdata = '0;
  logic          bp_wr = 1'b0;
  logic [PW-1:0] bp_wdata = '0;
  logic [PW-1:0] pc = '0;
  logic          retire = 1'b0;
  logic          run_en;
  logic          halted;
  logic [2:0]    ctl_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  run_ctl_unit #(.PC_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .bp_wr(bp_wr), .bp_wdata(bp_wdata), .pc(pc),
    .retire(retire), .run_en(run_en), .halted(halted), .ctl_rdata(ctl_rdata)
  );

  // Row: wr, wdata[3], bp_wr, bp_data[16], core_rst, pc[16], retire,
  //      exp run_en, exp halted, exp readback[3]
  // Expected values are the state seen in the cycle the inputs are applied.
  localparam logic [43:0] TBL [NROWS] = '{
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h10,1'b1, 1'b1,1'b0,3'd0}, // 0  R1 free run
    {1'b1,3'd1,1'b0,16'h0,1'b0,16'h11,1'b0, 1'b1,1'b0,3'd0}, // 1  halt write
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h11,1'b0, 1'b0,1'b1,3'd1}, // 2  R3 parked
    {1'b1,3'd3,1'b0,16'h0,1'b0,16'h11,1'b0, 1'b0,1'b1,3'd1}, // 3  step write
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h11,1'b0, 1'b1,1'b0,3'd3}, // 4  R10 waiting
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h11,1'b0, 1'b1,1'b0,3'd3}, // 5  R10 waiting
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h11,1'b1, 1'b1,1'b0,3'd3}, // 6  R4 retire
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h12,1'b0, 1'b0,1'b1,3'd1}, // 7  R4 R5 reparked
    {1'b1,3'd2,1'b0,16'h0,1'b0,16'h12,1'b0, 1'b0,1'b1,3'd1}, // 8  step w/o halt
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h12,1'b1, 1'b1,1'b0,3'd0}, // 9  R6
    {1'b0,3'd0,1'b1,16'h40,1'b0,16'h12,1'b1,1'b1,1'b0,3'd0}, // 10 bp addr
    {1'b1,3'd4,1'b0,16'h0,1'b0,16'h13,1'b1, 1'b1,1'b0,3'd0}, // 11 arm
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h40,1'b0, 1'b0,1'b0,3'd4}, // 12 R7 match
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h40,1'b0, 1'b0,1'b1,3'd1}, // 13 R7 R8
    {1'b1,3'd3,1'b0,16'h0,1'b0,16'h40,1'b0, 1'b0,1'b1,3'd1}, // 14 step write
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h40,1'b1, 1'b1,1'b0,3'd3}, // 15 R4 step
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h41,1'b0, 1'b0,1'b1,3'd1}, // 16 R4
    {1'b1,3'd0,1'b0,16'h0,1'b0,16'h41,1'b0, 1'b0,1'b1,3'd1}, // 17 resume
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h40,1'b1, 1'b1,1'b0,3'd0}, // 18 R11 R8
    {1'b1,3'd5,1'b0,16'h0,1'b0,16'h40,1'b0, 1'b1,1'b0,3'd0}, // 19 halt+arm
    {1'b1,3'd7,1'b0,16'h0,1'b0,16'h40,1'b0, 1'b0,1'b1,3'd5}, // 20 step+arm
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h40,1'b1, 1'b1,1'b0,3'd7}, // 21 R12
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h41,1'b0, 1'b0,1'b1,3'd5}, // 22 R12 kept
    {1'b1,3'd0,1'b0,16'h0,1'b1,16'h0,1'b0,  1'b0,1'b1,3'd5}, // 23 R2
    {1'b1,3'd4,1'b1,16'h80,1'b1,16'h0,1'b0, 1'b0,1'b0,3'd0}, // 24 R2 arm
    {1'b0,3'd0,1'b0,16'h0,1'b1,16'h0,1'b0,  1'b0,1'b0,3'd4}, // 25 R2 stays
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h80,1'b0, 1'b0,1'b0,3'd4}, // 26 R9 release
    {1'b0,3'd0,1'b0,16'h0,1'b0,16'h80,1'b0, 1'b0,1'b1,3'd1}  // 27 R9 parked
  };

  function automatic string row_tag(input int i);
    case (i)
      0: return "R1";
      2: return "R3";
      4, 5: return "R10";
      6, 7, 15, 16: return "R4";
      9: return "R6";
      12: return "R7";
      13: return "R8";
      18: return "R11";
      21, 22: return "R12";
      23, 24, 25: return "R2";
      26, 27: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "run_en in reset", {31'b0, run_en}, 32'd1);
    chk("R1", "halted in reset", {31'b0, halted}, 32'd0);
    chk("R1", "readback in reset", {29'b0, ctl_rdata}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      @(posedge clk);
      #1;
      ctl_wr    = TBL[i][43];
      ctl_wdata = TBL[i][42:40];
      bp_wr     = TBL[i][39];
      bp_wdata  = TBL[i][38:23];
      core_rst  = TBL[i][22];
      pc        = TBL[i][21:6];
      retire    = TBL[i][5];
      #1;
      chk(row_tag(i), "run_en", {31'b0, run_en}, {31'b0, TBL[i][4]});
      chk(row_tag(i), "halted", {31'b0, halted}, {31'b0, TBL[i][3]});
      chk(row_tag(i), "readback", {29'b0, ctl_rdata}, {29'b0, TBL[i][2:0]});
    end

    // R5: step bit visible as set during the grant, then cleared
    @(posedge clk); #1;
    ctl_wr = 1'b1; ctl_wdata = 3'd3; retire = 1'b0; pc = 16'h90;
    @(posedge clk); #1;
    ctl_wr = 1'b0;
    #1;
    chk("R5", "step bit open", {29'b0, ctl_rdata}, 32'd3);
    retire = 1'b1;
    @(posedge clk); #1;
    retire = 1'b0;
    #1;
    chk("R5", "step bit cleared", {29'b0, ctl_rdata}, 32'd1);
    chk("R4", "one retire only", {31'b0, run_en}, 32'd0);

    // R1: controller reset mid-operation returns to the free-running state
    rst_n = 1'b0;
    #1;
    chk("R1", "readback after reset", {29'b0, ctl_rdata}, 32'd0);
    chk("R1", "run_en after reset", {31'b0, run_en}, 32'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;

    finish_run();
  end
endmodule